// File: doc/BRIEF.md
# Crossbar Element Permutation Unit

This execute-stage unit rearranges the elements of a 32-bit operand. The second source operand is read as a row of equal-width indices. For each index, the unit fetches the element of the first operand at that index and places it in the slot where the index sits. The element width is 4, 8 or 16 bits. The instruction word selects the width: the unit compares the word, with its register fields masked off, against three fixed R-type encodings.

The unit is purely combinational. The result and the hit flag follow the operands and the instruction word in the same cycle, with no clock and no reset. An index that points past the end of the 32-bit operand produces a zero element in its slot; it does not wrap. When no encoding matches, the hit flag is low and the result is zero. The core's own pipeline surrounds the unit and handles register access.

Top module: `xperm_unit`

## Requirements
- R1: `hit` is 1 exactly when `(instr & 32'hFE00707F)` equals one of 32'h28002033 (nibble), 32'h28004033 (byte) or 32'h28006033 (halfword). The bits of rd [11:7], rs1 [19:15] and rs2 [24:20] have no effect on the match.
- R2: When no encoding matches, `hit` is 0 and `result` is 32'h0, whatever the operands are.
- R3: Nibble mode uses 4-bit elements at bit offsets 4*i. Index n selects `src1[4n+3:4n]` for n < 8.
- R4: Byte mode uses 8-bit elements at bit offsets 8*i. Index n selects `src1[8n+7:8n]` for n < 4.
- R5: Halfword mode uses 16-bit elements at bit offsets 16*i. Only index values 0 and 1 are in range; index 0 selects `src1[15:0]` and index 1 selects `src1[31:16]`.
- R6: When every index equals its own element position, `result` equals `src1` in all three modes.
- R7: An index whose selected bit position (index shifted left by log2 of the element width) is 32 or more gives a zero element. Each element slot is decided only by its own index, so one out-of-range index does not change any other slot.
- R8: `result` and `hit` are valid in the same cycle as their inputs; no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| src1 | input | 32 | Data operand whose elements are selected |
| src2 | input | 32 | Row of element indices |
| hit | output | 1 | High when the instruction is one of the three permute encodings |
| result | output | 32 | Permuted data, or zero when there is no hit |

## Verification
The immediate assertions assume that the inputs have settled to known 0/1 values when they are evaluated. The bench therefore drives every input with a defined value from time zero and changes them only on the falling clock edge. The identity assertion and the out-of-range assertion take no position on operand content. This lets the stimulus mix hand-picked index patterns (identity, reversal, broadcast, all out-of-range) with free random operands. To reach the in-range case often, some random index words are masked down to small values.

// File: rtl/xperm_pkg.sv
package xperm_pkg;

  localparam int unsigned XP_XLEN = 32;

  // opcode/funct3/funct7 survive the mask; register fields are cleared
  localparam logic [31:0] XP_MATCH_MASK = 32'hFE00707F;
  localparam logic [31:0] XP_ENC_NIB    = 32'h28002033;
  localparam logic [31:0] XP_ENC_BYTE   = 32'h28004033;
  localparam logic [31:0] XP_ENC_HALF   = 32'h28006033;

  localparam int unsigned XP_NUM_SIZES = 3;
  localparam int unsigned XP_MIN_LOG2  = 2;

  typedef enum logic [1:0] {
    XP_SZ_NIB  = 2'd0,
    XP_SZ_BYTE = 2'd1,
    XP_SZ_HALF = 2'd2,
    XP_SZ_NONE = 2'd3
  } xp_size_e;

  // an index is usable when index << log2_elem stays below the operand width
  function automatic logic xp_in_range(input int unsigned idx,
                                       input int unsigned log2_elem,
                                       input int unsigned xlen);
    return idx < (xlen >> log2_elem);
  endfunction

  // the encoding each size slot answers to
  function automatic logic [31:0] xp_encoding(input int unsigned slot);
    case (slot)
      0:       return XP_ENC_NIB;
      1:       return XP_ENC_BYTE;
      default: return XP_ENC_HALF;
    endcase
  endfunction

endpackage

// File: rtl/xperm_decode.sv
module xperm_decode
  import xperm_pkg::*;
(
  input  logic [31:0]             instr,
  output logic                    hit,
  output logic [XP_NUM_SIZES-1:0] size_sel,
  output xp_size_e                size
);

  logic [31:0] masked;
  assign masked = instr & XP_MATCH_MASK;

  for (genvar g = 0; g < XP_NUM_SIZES; g++) begin : g_match
    assign size_sel[g] = (masked == xp_encoding(g));
  end

  assign hit = |size_sel;

  always_comb begin
    unique case (1'b1)
      size_sel[0]: size = XP_SZ_NIB;
      size_sel[1]: size = XP_SZ_BYTE;
      size_sel[2]: size = XP_SZ_HALF;
      default:     size = XP_SZ_NONE;
    endcase
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(size_sel)) else $error("size select not one-hot"); // R1
    if (instr[6:0] != 7'b0110011)
      AST_OPCODE_GATE: assert (!hit) else $error("hit on foreign opcode"); // R1
  end

endmodule

// File: rtl/xperm_engine.sv
module xperm_engine
  import xperm_pkg::*;
#(
  parameter  int unsigned XLEN      = XP_XLEN,
  parameter  int unsigned LOG2_ELEM = 2,
  localparam int unsigned ELEM      = 1 << LOG2_ELEM,
  localparam int unsigned NELEM     = XLEN / ELEM,
  localparam int unsigned POSW      = ELEM + LOG2_ELEM
)(
  input  logic [XLEN-1:0]  src1,
  input  logic [XLEN-1:0]  src2,
  output logic [XLEN-1:0]  res,
  output logic [NELEM-1:0] oob
);

  for (genvar j = 0; j < NELEM; j++) begin : g_elem
    logic [ELEM-1:0] idx;
    logic [POSW-1:0] bitpos;

    assign idx    = src2[j*ELEM +: ELEM];
    assign bitpos = POSW'(idx) << LOG2_ELEM;
    assign oob[j] = !xp_in_range(32'(idx), LOG2_ELEM, XLEN);
    assign res[j*ELEM +: ELEM] = oob[j] ? '0 : ELEM'(src1 >> bitpos);

    always_comb begin
      if (oob[j])
        AST_OOB_SLOT_ZERO: assert (res[j*ELEM +: ELEM] == '0) else $error("out-of-range slot not zero"); // R7
      if (32'(idx) == j)
        AST_IDENTITY_SLOT: assert (res[j*ELEM +: ELEM] == src1[j*ELEM +: ELEM]) else $error("identity slot mismatch"); // R6
    end
  end

endmodule

// File: rtl/xperm_unit.sv
module xperm_unit
  import xperm_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] src1,
  input  logic [31:0] src2,
  output logic        hit,
  output logic [31:0] result
);

  logic [XP_NUM_SIZES-1:0] size_sel;
  xp_size_e                size;
  logic [31:0]             eng_res [XP_NUM_SIZES];

  xperm_decode u_decode (
    .instr    (instr),
    .hit      (hit),
    .size_sel (size_sel),
    .size     (size)
  );

  for (genvar g = 0; g < XP_NUM_SIZES; g++) begin : g_size
    localparam int unsigned L2 = XP_MIN_LOG2 + g;
    logic [(32 >> L2)-1:0] oob;

    xperm_engine #(.XLEN(32), .LOG2_ELEM(L2)) u_engine (
      .src1 (src1),
      .src2 (src2),
      .res  (eng_res[g]),
      .oob  (oob)
    );

    // all indices out of range must give an all-zero result in this mode
    always_comb begin
      if (size_sel[g] && (&oob))
        AST_ALL_OOB_ZERO: assert (result == 32'h0) else $error("all-oob result not zero"); // R7
    end
  end

  always_comb begin
    case (size)
      XP_SZ_NIB:  result = eng_res[0];
      XP_SZ_BYTE: result = eng_res[1];
      XP_SZ_HALF: result = eng_res[2];
      default:    result = 32'h0;
    endcase
  end

  always_comb begin
    if (!hit)
      AST_MISS_ZERO: assert (result == 32'h0) else $error("result nonzero without hit"); // R2
    if (size_sel[2] && src2 == 32'h0000_0001)
      AST_HALF_SWAP_LOW: assert (result[15:0] == src1[31:16]) else $error("halfword index 1 wrong"); // R5
  end

endmodule

// File: tb/xperm_unit_tb.sv
module xperm_unit_tb;

  logic        clk = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] src1  = 32'h0;
  logic [31:0] src2  = 32'h0;
  logic        hit;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  xperm_unit u_dut (
    .instr  (instr),
    .src1   (src1),
    .src2   (src2),
    .hit    (hit),
    .result (result)
  );

  localparam logic [31:0] ENC_N = 32'h28002033;
  localparam logic [31:0] ENC_B = 32'h28004033;
  localparam logic [31:0] ENC_H = 32'h28006033;
  localparam logic [31:0] REG_FIELDS = 32'h01FF8F80;

  // behavioural model: walk the element positions with integers
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input int lg);
    logic [31:0] r = 32'h0;
    int sz = 1 << lg;
    for (int i = 0; i < 32; i += sz) begin
      longint unsigned ix = 0;
      for (int t = 0; t < sz; t++) ix[t] = b[i+t];
      if ((ix << lg) < 32) begin
        for (int t = 0; t < sz; t++) r[i+t] = a[(ix << lg) + t];
      end
    end
    return r;
  endfunction

  function automatic int size_of(input logic [31:0] w);
    logic [31:0] m = w & ~REG_FIELDS;
    if (m == ENC_N) return 2;
    if (m == ENC_B) return 3;
    if (m == ENC_H) return 4;
    return -1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (instr %h src1 %h src2 %h)",
               req, got, exp, instr, src1, src2);
    end
  endtask

  // one vector per clock: drive on the falling edge, sample 1 ns later
  task automatic apply(input string req, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b);
    int lg;
    @(negedge clk);
    instr = w; src1 = a; src2 = b;
    #1;
    lg = size_of(w);
    check({req, " hit"}, {31'h0, hit}, {31'h0, (lg > 0)});
    check({req, " result"}, result, (lg > 0) ? model(a, b, lg) : 32'h0);
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] enc [3];
    enc[0] = ENC_N; enc[1] = ENC_B; enc[2] = ENC_H;

    // idle state before any edge
    #1;
    check("R2 idle hit", {31'h0, hit}, 32'h0);
    check("R2 idle result", result, 32'h0);

    // R2: near-miss encodings
    apply("R2 funct3", 32'h28000033, 32'hDEADBEEF, 32'h0);
    apply("R2 opcode", 32'h2800203B, 32'hDEADBEEF, 32'h0);
    apply("R2 funct7", 32'h2A002033, 32'hDEADBEEF, 32'h76543210);
    apply("R2 bit31",  32'hA8004033, 32'h12345678, 32'h03020100);

    // R1: register fields are don't-care
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 6; r++)
        apply("R1 regfields", enc[s] | ($urandom & REG_FIELDS), $urandom, $urandom);
      apply("R1 all regbits", enc[s] | REG_FIELDS, 32'hCAFEF00D, 32'h0);
    end

    // R3 nibble
    apply("R3 R6 nib identity", ENC_N, 32'h89ABCDEF, 32'h76543210);
    apply("R3 nib reverse",     ENC_N, 32'h89ABCDEF, 32'h01234567);
    apply("R3 nib broadcast",   ENC_N, 32'h89ABCDEF, 32'h77777777);
    apply("R7 nib all oob",     ENC_N, 32'hFFFFFFFF, 32'hFEDCBA98);
    apply("R7 nib mixed",       ENC_N, 32'h89ABCDEF, 32'h8F2A0B31);

    // R4 byte
    apply("R4 R6 byte identity", ENC_B, 32'hA1B2C3D4, 32'h03020100);
    apply("R4 byte broadcast",   ENC_B, 32'hA1B2C3D4, 32'h00000000);
    apply("R4 R7 byte mixed",    ENC_B, 32'hA1B2C3D4, 32'h04FF0201);
    apply("R7 byte all oob",     ENC_B, 32'hFFFFFFFF, 32'h80FF0504);

    // R5 halfword
    apply("R5 R6 half identity", ENC_H, 32'h1234ABCD, 32'h00010000);
    apply("R5 half swap",        ENC_H, 32'h1234ABCD, 32'h00000001);
    apply("R5 R7 half idx2",     ENC_H, 32'h1234ABCD, 32'h00020001);
    apply("R7 half all oob",     ENC_H, 32'hFFFFFFFF, 32'hFFFF0002);

    // R8: change operands between edges and observe without an edge
    @(negedge clk);
    instr = ENC_B; src1 = 32'h11223344; src2 = 32'h00010203;
    #0.5;
    check("R8 same cycle", result, 32'h44332211);
    src2 = 32'h03030303;
    #0.5;
    check("R8 same cycle update", result, 32'h11111111);

    // random sweep per size, half with indices masked small
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 150; r++) begin
        logic [31:0] b = $urandom;
        if (r[0]) b = b & ((s == 0) ? 32'h77777777 : (s == 1) ? 32'h03030303 : 32'h00010001);
        apply((s == 0) ? "R3 random" : (s == 1) ? "R4 random" : "R5 random",
              enc[s], $urandom, b);
      end
    end

    // R2 random foreign words
    for (int r = 0; r < 50; r++) begin
      logic [31:0] w = $urandom;
      apply("R2 random word", w, $urandom, $urandom);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule